// File: doc/BRIEF.md
# Host-to-Firmware Command Mailbox

This block is a small shared register file sitting between a host bus and an embedded microcontroller. It holds five byte-wide registers: a command byte, three argument bytes and a configuration byte. The host posts a request by writing the arguments and then a nonzero command. While the command byte is nonzero, a firmware interrupt line is asserted. The firmware runs the request, writes a status code into the first argument and then clears the command byte, which drops the interrupt.

Two bits of the configuration byte drive control outputs. One holds the embedded CPU in reset, so that it stops fetching instructions, for example while flash is being rewritten. The other allows the CPU to issue write cycles to off-chip memory. When that bit is clear, CPU writes reach only on-chip peripherals. Each side has its own synchronous port with a byte address, a write enable, write data and registered read data.

The command codes are used by software only; the block does not decode them. They are 01h status query, 02h idle, 03h power down and 04h flash-write preparation. For 04h, argument 1 set to 01h means the whole flash including the CPU code region, and 02h means the system region only. The completion status in argument 1 is 00h success, 01h failure because no AC adapter is present, and 02h failure for an unknown cause.

Top module: `hfw_mailbox`

## Requirements
- R1: After a synchronous reset, every register reads 00h from both ports, and `fw_irq`, `cpu_hold_rst` and `cpu_ext_wr_en` are 0.
- R2: The command, argument 1, argument 2, argument 3 and configuration registers live at byte addresses 10h, 11h, 12h, 13h and 14h. Each is writable and readable from both ports, and read data is registered, appearing one cycle after the address.
- R3: A read from any other address returns 00h, and a write to any other address changes no register.
- R4: `fw_irq` becomes 1 one cycle after the command register holds a nonzero value. It stays 1 for as long as the command register stays nonzero, including while other registers are written.
- R5: When the firmware writes 00h to the command register, `fw_irq` falls one cycle later. The status the firmware wrote into argument 1 (00h success, 01h no AC adapter, 02h unknown) is then readable by the host.
- R6: When both ports write the same register in the same cycle, the host value is stored. When they write different registers in the same cycle, both values are stored.
- R7: `cpu_hold_rst` follows configuration bit 0 and `cpu_ext_wr_en` follows configuration bit 6, each one cycle after the configuration register changes.
- R8: A read of a register in the same cycle as a write to it returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host byte address |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| fw_addr | input | 8 | Firmware byte address |
| fw_we | input | 1 | Firmware write enable |
| fw_wdata | input | 8 | Firmware write data |
| fw_rdata | output | 8 | Firmware read data, registered |
| fw_irq | output | 1 | Command-pending interrupt to the firmware |
| cpu_hold_rst | output | 1 | Holds the embedded CPU in reset |
| cpu_ext_wr_en | output | 1 | Allows CPU write cycles to off-chip memory |

## Verification
Two functions can fall in the same clock edge: a host write and a firmware write to the same register, and a read of a register together with a write to it. The bench provokes the first by driving both write ports at one address, including the command byte, and by driving them at two different addresses. It judges the result by reading back from both ports and by watching the interrupt. It provokes the second by reading a register while writing it, and expects the old value first and the new value on the next read.

// File: rtl/hfw_mbox_pkg.sv
package hfw_mbox_pkg;
  localparam int unsigned NUM_REGS     = 5;
  localparam int unsigned IDX_CMD      = 0;
  localparam int unsigned IDX_ARG1     = 1;
  localparam int unsigned IDX_ARG2     = 2;
  localparam int unsigned IDX_ARG3     = 3;
  localparam int unsigned IDX_CFG      = 4;
  localparam int unsigned CFG_HOLD_BIT = 0;
  localparam int unsigned CFG_EXWR_BIT = 6;
endpackage

// File: rtl/hfw_mbox_regs.sv
module hfw_mbox_regs
  import hfw_mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_we,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_we,
  input  logic [DATA_W-1:0] f_wdata,
  output logic [DATA_W-1:0] f_rdata,
  output logic [DATA_W-1:0] regs_o [NUM_REGS]
);

  logic [NUM_REGS-1:0] h_hit;
  logic [NUM_REGS-1:0] f_hit;
  logic [DATA_W-1:0]   mb_q [NUM_REGS];
  logic [DATA_W-1:0]   h_rd_nxt;
  logic [DATA_W-1:0]   f_rd_nxt;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign h_hit[g] = (h_addr == ADDR_W'(BASE_ADDR + g));
    assign f_hit[g] = (f_addr == ADDR_W'(BASE_ADDR + g));

    // host side wins a same-register collision
    always_ff @(posedge clk) begin
      if (rst)                  mb_q[g] <= '0;
      else if (h_we && h_hit[g]) mb_q[g] <= h_wdata;
      else if (f_we && f_hit[g]) mb_q[g] <= f_wdata;
    end

    assign regs_o[g] = mb_q[g];

    // R6
    host_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (h_we && h_hit[g]) |=> (mb_q[g] == $past(h_wdata)));

    // R6
    fw_alone_chk: assert property (@(posedge clk) disable iff (rst)
      (f_we && f_hit[g] && !(h_we && h_hit[g])) |=> (mb_q[g] == $past(f_wdata)));
  end

  always_comb begin
    h_rd_nxt = '0;
    f_rd_nxt = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (h_hit[i]) h_rd_nxt = mb_q[i];
      if (f_hit[i]) f_rd_nxt = mb_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata <= '0;
      f_rdata <= '0;
    end else begin
      h_rdata <= h_rd_nxt;
      f_rdata <= f_rd_nxt;
    end
  end

  // R3
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (h_hit == '0) |=> (h_rdata == '0));

endmodule

// File: rtl/hfw_mbox_ctrl.sv
module hfw_mbox_ctrl
  import hfw_mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic [DATA_W-1:0] cfg_i,
  output logic              irq_o,
  output logic              hold_o,
  output logic              exwr_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      hold_o <= 1'b0;
      exwr_o <= 1'b0;
    end else begin
      irq_o  <= |cmd_i;
      hold_o <= cfg_i[CFG_HOLD_BIT];
      exwr_o <= cfg_i[CFG_EXWR_BIT];
    end
  end

  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i != '0) |=> irq_o);

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == '0) |=> !irq_o);

  // R7
  hold_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_i[CFG_HOLD_BIT]) |=> hold_o);

  // R7
  exwr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_i[CFG_EXWR_BIT]) |=> !exwr_o);

endmodule

// File: rtl/hfw_mailbox.sv
module hfw_mailbox
  import hfw_mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic              fw_we,
  input  logic [DATA_W-1:0] fw_wdata,
  output logic [DATA_W-1:0] fw_rdata,
  output logic              fw_irq,
  output logic              cpu_hold_rst,
  output logic              cpu_ext_wr_en
);

  logic [DATA_W-1:0] regs_w [NUM_REGS];

  hfw_mbox_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE_ADDR(BASE_ADDR)
  ) regs_i (
    .clk    (clk),
    .rst    (rst),
    .h_addr (host_addr),
    .h_we   (host_we),
    .h_wdata(host_wdata),
    .h_rdata(host_rdata),
    .f_addr (fw_addr),
    .f_we   (fw_we),
    .f_wdata(fw_wdata),
    .f_rdata(fw_rdata),
    .regs_o (regs_w)
  );

  hfw_mbox_ctrl #(
    .DATA_W(DATA_W)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .cmd_i (regs_w[IDX_CMD]),
    .cfg_i (regs_w[IDX_CFG]),
    .irq_o (fw_irq),
    .hold_o(cpu_hold_rst),
    .exwr_o(cpu_ext_wr_en)
  );

endmodule

// File: tb/hfw_mailbox_tb_top.sv
module hfw_mailbox_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] host_addr, host_wdata, fw_addr, fw_wdata;
  logic       host_we, fw_we;
  logic [7:0] host_rdata, fw_rdata;
  logic       fw_irq, cpu_hold_rst, cpu_ext_wr_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hfw_mailbox dut_i (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fw_addr(fw_addr), .fw_we(fw_we), .fw_wdata(fw_wdata), .fw_rdata(fw_rdata),
    .fw_irq(fw_irq), .cpu_hold_rst(cpu_hold_rst), .cpu_ext_wr_en(cpu_ext_wr_en)
  );

  // {fw_side, addr, wdata, expected readback from the other port}
  localparam logic [24:0] VEC [9] = '{
    {1'b0, 8'h10, 8'h01, 8'h01},   // R2 command
    {1'b0, 8'h11, 8'h02, 8'h02},   // R2 arg1
    {1'b0, 8'h12, 8'h5A, 8'h5A},   // R2 arg2
    {1'b0, 8'h13, 8'hC3, 8'hC3},   // R2 arg3
    {1'b1, 8'h11, 8'h00, 8'h00},   // R2 firmware status
    {1'b1, 8'h10, 8'h00, 8'h00},   // R2 firmware clears command
    {1'b0, 8'h15, 8'hFF, 8'h00},   // R3 unmapped host write
    {1'b1, 8'h0F, 8'h12, 8'h00},   // R3 unmapped firmware write
    {1'b0, 8'h14, 8'h00, 8'h00}    // R2 config
  };

  task automatic step(input logic hw, input logic [7:0] ha, input logic [7:0] hd,
                      input logic fw, input logic [7:0] fa, input logic [7:0] fd);
    @(negedge clk);
    host_we = hw; host_addr = ha; host_wdata = hd;
    fw_we = fw; fw_addr = fa; fw_wdata = fd;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    host_we = 0; host_addr = 0; host_wdata = 0;
    fw_we = 0; fw_addr = 0; fw_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk({5'd0, fw_irq, cpu_hold_rst, cpu_ext_wr_en}, 8'h00, "R1 outputs");
    for (int a = 16; a < 21; a++) begin
      step(0, 8'(a), 0, 0, 8'(a), 0);
      chk(host_rdata, 8'h00, "R1 host read");
      chk(fw_rdata, 8'h00, "R1 fw read");
    end

    // vector table: write on one port, read back on the other
    for (int i = 0; i < 9; i++) begin
      if (VEC[i][24]) step(0, 0, 0, 1, VEC[i][23:16], VEC[i][15:8]);
      else            step(1, VEC[i][23:16], VEC[i][15:8], 0, 0, 0);
      step(0, VEC[i][23:16], 0, 0, VEC[i][23:16], 0);
      if (VEC[i][24]) chk(host_rdata, VEC[i][7:0], "R2/R3 table host read");
      else            chk(fw_rdata, VEC[i][7:0], "R2/R3 table fw read");
    end
    step(0, 8'h00, 0, 0, 8'hFF, 0);
    chk(host_rdata, 8'h00, "R3 read 00h");
    chk(fw_rdata, 8'h00, "R3 read FFh");

    // R4: flash prep command, interrupt one cycle later, held
    step(1, 8'h10, 8'h04, 0, 0, 0);
    chk({7'd0, fw_irq}, 8'h00, "R4 irq lag");
    step(0, 0, 0, 0, 0, 0);
    chk({7'd0, fw_irq}, 8'h01, "R4 irq raised");
    step(1, 8'h11, 8'h01, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk({7'd0, fw_irq}, 8'h01, "R4 irq held");

    // R5: firmware status then clear
    step(0, 0, 0, 1, 8'h11, 8'h01);
    step(0, 0, 0, 1, 8'h10, 8'h00);
    chk({7'd0, fw_irq}, 8'h01, "R5 irq before drop");
    step(0, 8'h11, 0, 0, 0, 0);
    chk({7'd0, fw_irq}, 8'h00, "R5 irq dropped");
    chk(host_rdata, 8'h01, "R5 status no AC");

    // R6: same-register collision
    step(1, 8'h12, 8'hAA, 1, 8'h12, 8'h55);
    step(0, 8'h12, 0, 0, 8'h12, 0);
    chk(host_rdata, 8'hAA, "R6 collision host read");
    chk(fw_rdata, 8'hAA, "R6 collision fw read");
    // R6: collision on command byte, host nonzero beats firmware clear
    step(1, 8'h10, 8'h03, 1, 8'h10, 8'h00);
    step(0, 8'h10, 0, 0, 0, 0);
    chk({7'd0, fw_irq}, 8'h01, "R6 cmd collision irq");
    chk(host_rdata, 8'h03, "R6 cmd collision value");
    step(0, 0, 0, 1, 8'h10, 8'h00);
    // R6: different registers
    step(1, 8'h12, 8'h11, 1, 8'h13, 8'h22);
    step(0, 8'h12, 0, 0, 8'h13, 0);
    chk(host_rdata, 8'h11, "R6 split host");
    chk(fw_rdata, 8'h22, "R6 split fw");

    // R8: read during write returns old value
    step(1, 8'h13, 8'h99, 0, 8'h13, 0);
    chk(fw_rdata, 8'h22, "R8 fw old value");
    step(0, 8'h13, 0, 0, 0, 0);
    chk(host_rdata, 8'h99, "R8 new value");

    // R7: configuration outputs
    step(1, 8'h14, 8'h41, 0, 0, 0);
    chk({6'd0, cpu_hold_rst, cpu_ext_wr_en}, 8'h00, "R7 lag");
    step(0, 0, 0, 0, 0, 0);
    chk({6'd0, cpu_hold_rst, cpu_ext_wr_en}, 8'h03, "R7 both set");
    step(1, 8'h14, 8'h01, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk({6'd0, cpu_hold_rst, cpu_ext_wr_en}, 8'h02, "R7 hold only");
    step(0, 0, 0, 1, 8'h14, 8'h40);
    step(0, 0, 0, 0, 0, 0);
    chk({6'd0, cpu_hold_rst, cpu_ext_wr_en}, 8'h01, "R7 ext write only");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule